// File: doc/BRIEF.md
# Compare-Set and Branch Resolution Unit

This unit takes the two register operands of one instruction and decides every comparison-driven outcome for a simple load-store core. It produces a boolean set value for the compare-and-set family and resolves conditional branches and jumps to a next program counter. For the link forms it also produces the return address together with its write-enable. A branch can test a register for zero, a register's sign, two registers for equality, or a condition bit supplied by an external floating-point comparator.

All results are registered. An operation presented on the inputs in one cycle appears on the outputs after the next rising clock edge. Instruction decode, hazard handling and the floating-point compare itself happen elsewhere. The block only consumes a 5-bit operation code and the floating-point condition bit.

Top module: `cond_resolve_unit`

## Requirements
- R1: For set operations, `set_o` is 1 when the condition holds and 0 otherwise, with all upper bits zero. For every other operation `set_o` is 0.
- R2: Signed set operations compare the operands as two's complement numbers: SLT=1 (a<b), SGT=3 (a>b), SLE=5 (a<=b), SGE=7 (a>=b).
- R3: Unsigned set operations compare the operands as unsigned numbers: SLTU=2, SGTU=4, SLEU=6, SGEU=8.
- R4: SEQ=9 sets the result when a==b, and SNE=10 sets it when a!=b.
- R5: BEQZ=11 is taken when operand a is zero, and BNEZ=12 is taken when a is nonzero.
- R6: BLTZ=13 is taken when bit 63 of a is 1, and BGEZ=14 is taken when that bit is 0.
- R7: BEQ=15 is taken when a==b, and BNE=16 is taken when a!=b.
- R8: BFPT=17 is taken when `fp_cond_i` is 1, and BFPF=18 is taken when it is 0.
- R9: A taken branch gives next PC = PC+4 + (sign-extended 16-bit offset << 2). Every not-taken branch, every set operation and every NOP gives next PC = PC+4.
- R10: Jumps are always taken. J=19 and JAL=20 target {PC+4 bits 63:28, 26-bit field, 2'b00}. JR=21 and JALR=22 target operand a unchanged.
- R11: Only JAL and JALR raise `link_we_o`. When they do, `link_o` = PC+4 and `link_rd_o` = 31. For all other operations `link_we_o` and `link_o` are 0.
- R12: Results appear one clock after their inputs. During reset all outputs are 0. Codes 0 and 23..31 behave as NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code |
| rs_a_i | input | 64 | First operand |
| rs_b_i | input | 64 | Second operand |
| pc_i | input | 64 | PC of the instruction |
| br_off_i | input | 16 | Branch word offset, signed |
| jmp_field_i | input | 26 | Immediate jump target field |
| fp_cond_i | input | 1 | Floating-point condition bit |
| set_o | output | 64 | Set result (0 or 1) |
| taken_o | output | 1 | Control transfer taken |
| next_pc_o | output | 64 | Resolved next PC |
| link_we_o | output | 1 | Link write-enable |
| link_rd_o | output | 5 | Link destination register |
| link_o | output | 64 | Return address |

## Verification
The bench aims at operand pairs where signed and unsigned order disagree, such as the most negative value against 1, or all-ones against zero. A design that used one comparator for both forms would return the wrong set bit on exactly these pairs. Equal operands are forced often, so that a design that confused the less-or-equal and greater-or-equal conditions with their strict forms is caught. The bench also drives the most negative branch offset, a PC near the top of the address space and unused operation codes. These cases expose a design that zero-extends the offset, loses the upper PC bits on an immediate jump, or links on an undefined code.

// File: rtl/cru_pkg.sv
package cru_pkg;
  typedef enum logic [4:0] {
    OP_NOP  = 5'd0,
    OP_SLT  = 5'd1,  OP_SLTU = 5'd2,
    OP_SGT  = 5'd3,  OP_SGTU = 5'd4,
    OP_SLE  = 5'd5,  OP_SLEU = 5'd6,
    OP_SGE  = 5'd7,  OP_SGEU = 5'd8,
    OP_SEQ  = 5'd9,  OP_SNE  = 5'd10,
    OP_BEQZ = 5'd11, OP_BNEZ = 5'd12,
    OP_BLTZ = 5'd13, OP_BGEZ = 5'd14,
    OP_BEQ  = 5'd15, OP_BNE  = 5'd16,
    OP_BFPT = 5'd17, OP_BFPF = 5'd18,
    OP_J    = 5'd19, OP_JAL  = 5'd20,
    OP_JR   = 5'd21, OP_JALR = 5'd22
  } op_e;

  typedef struct packed {
    logic eq;
    logic lt_s;
    logic lt_u;
    logic a_zero;
    logic a_neg;
  } cmp_flags_t;

  typedef struct packed {
    logic set_bit;
    logic br_take;
    logic jump;
    logic jump_reg;
    logic link;
  } decide_t;
endpackage

// File: rtl/cru_compare.sv
module cru_compare
  import cru_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output cmp_flags_t      flags_o
);
  always_comb begin
    flags_o.eq     = (a_i == b_i);
    flags_o.lt_u   = (a_i < b_i);
    flags_o.lt_s   = ($signed(a_i) < $signed(b_i));
    flags_o.a_zero = (a_i == '0);
    flags_o.a_neg  = a_i[XLEN-1];
  end
endmodule

// File: rtl/cru_target.sv
module cru_target #(
  parameter int XLEN  = 64,
  parameter int OFF_W = 16,
  parameter int JT_W  = 26
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [JT_W-1:0]  jfield_i,
  output logic [XLEN-1:0]  pc4_o,
  output logic [XLEN-1:0]  br_tgt_o,
  output logic [XLEN-1:0]  jimm_tgt_o
);
  localparam int SEXT_W = XLEN - OFF_W - 2;
  localparam int HI_W   = XLEN - JT_W - 2;

  logic [XLEN-1:0] off_x;

  assign pc4_o      = pc_i + XLEN'(4);
  assign off_x      = {{SEXT_W{off_i[OFF_W-1]}}, off_i, 2'b00};
  assign br_tgt_o   = pc4_o + off_x;
  assign jimm_tgt_o = {pc4_o[XLEN-1 -: HI_W], jfield_i, 2'b00};
endmodule

// File: rtl/cru_decide.sv
module cru_decide
  import cru_pkg::*;
(
  input  logic [4:0]  op_i,
  input  cmp_flags_t  flags_i,
  input  logic        fp_cond_i,
  output decide_t     dec_o
);
  op_e op;
  assign op = op_e'(op_i);

  always_comb begin
    dec_o = '0;
    unique case (op)
      OP_SLT:  dec_o.set_bit = flags_i.lt_s;
      OP_SLTU: dec_o.set_bit = flags_i.lt_u;
      OP_SGT:  dec_o.set_bit = !flags_i.lt_s && !flags_i.eq;
      OP_SGTU: dec_o.set_bit = !flags_i.lt_u && !flags_i.eq;
      OP_SLE:  dec_o.set_bit = flags_i.lt_s || flags_i.eq;
      OP_SLEU: dec_o.set_bit = flags_i.lt_u || flags_i.eq;
      OP_SGE:  dec_o.set_bit = !flags_i.lt_s;
      OP_SGEU: dec_o.set_bit = !flags_i.lt_u;
      OP_SEQ:  dec_o.set_bit = flags_i.eq;
      OP_SNE:  dec_o.set_bit = !flags_i.eq;
      OP_BEQZ: dec_o.br_take = flags_i.a_zero;
      OP_BNEZ: dec_o.br_take = !flags_i.a_zero;
      OP_BLTZ: dec_o.br_take = flags_i.a_neg;
      OP_BGEZ: dec_o.br_take = !flags_i.a_neg;
      OP_BEQ:  dec_o.br_take = flags_i.eq;
      OP_BNE:  dec_o.br_take = !flags_i.eq;
      OP_BFPT: dec_o.br_take = fp_cond_i;
      OP_BFPF: dec_o.br_take = !fp_cond_i;
      OP_J:    dec_o.jump = 1'b1;
      OP_JAL:  begin dec_o.jump = 1'b1; dec_o.link = 1'b1; end
      OP_JR:   begin dec_o.jump = 1'b1; dec_o.jump_reg = 1'b1; end
      OP_JALR: begin dec_o.jump = 1'b1; dec_o.jump_reg = 1'b1; dec_o.link = 1'b1; end
      default: dec_o = '0;
    endcase
  end
endmodule

// File: rtl/cond_resolve_unit.sv
module cond_resolve_unit
  import cru_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int OFF_W    = 16,
  parameter int JT_W     = 26,
  parameter int RIDX_W   = 5,
  parameter int LINK_REG = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        op_i,
  input  logic [XLEN-1:0]   rs_a_i,
  input  logic [XLEN-1:0]   rs_b_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [OFF_W-1:0]  br_off_i,
  input  logic [JT_W-1:0]   jmp_field_i,
  input  logic              fp_cond_i,
  output logic [XLEN-1:0]   set_o,
  output logic              taken_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              link_we_o,
  output logic [RIDX_W-1:0] link_rd_o,
  output logic [XLEN-1:0]   link_o
);
  localparam logic [RIDX_W-1:0] LINK_IDX = RIDX_W'(LINK_REG);

  cmp_flags_t      flags;
  decide_t         dec;
  logic [XLEN-1:0] pc4, br_tgt, jimm_tgt, npc_d;
  logic            primed_q;

  cru_compare #(.XLEN(XLEN)) u_cmp (
    .a_i(rs_a_i), .b_i(rs_b_i), .flags_o(flags)
  );

  cru_target #(.XLEN(XLEN), .OFF_W(OFF_W), .JT_W(JT_W)) u_tgt (
    .pc_i(pc_i), .off_i(br_off_i), .jfield_i(jmp_field_i),
    .pc4_o(pc4), .br_tgt_o(br_tgt), .jimm_tgt_o(jimm_tgt)
  );

  cru_decide u_dec (
    .op_i(op_i), .flags_i(flags), .fp_cond_i(fp_cond_i), .dec_o(dec)
  );

  always_comb begin
    if (dec.jump)         npc_d = dec.jump_reg ? rs_a_i : jimm_tgt;
    else if (dec.br_take) npc_d = br_tgt;
    else                  npc_d = pc4;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_o     <= '0;
      taken_o   <= 1'b0;
      next_pc_o <= '0;
      link_we_o <= 1'b0;
      link_rd_o <= '0;
      link_o    <= '0;
      primed_q  <= 1'b0;
    end else begin
      set_o     <= {{(XLEN-1){1'b0}}, dec.set_bit};
      taken_o   <= dec.jump || dec.br_take;
      next_pc_o <= npc_d;
      link_we_o <= dec.link;
      link_rd_o <= dec.link ? LINK_IDX : '0;
      link_o    <= dec.link ? pc4 : '0;
      primed_q  <= 1'b1;
    end
  end

  // assertions
  p_set_bool_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o <= XLEN'(1));

  p_set_no_take_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_o != '0) |-> !taken_o);

  p_fallthrough_r9: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed_q)
    !taken_o |-> (next_pc_o == $past(pc_i) + XLEN'(4)));

  p_jump_taken_r10: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed_q)
    ($past(op_i) inside {OP_J, OP_JAL, OP_JR, OP_JALR}) |-> taken_o);

  p_link_addr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed_q)
    link_we_o |-> (link_o == $past(pc_i) + XLEN'(4) && link_rd_o == LINK_IDX));

  p_link_only_jal_r11: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed_q)
    link_we_o |-> ($past(op_i) inside {OP_JAL, OP_JALR}));
endmodule

// File: tb/cond_resolve_unit_test.sv
`timescale 1ns/1ps
module cond_resolve_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op;
  logic [63:0] a, b, pc;
  logic [15:0] off;
  logic [25:0] jf;
  logic        fpc;
  logic [63:0] set_o, next_pc_o, link_o;
  logic        taken_o, link_we_o;
  logic [4:0]  link_rd_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cond_resolve_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .rs_a_i(a), .rs_b_i(b),
    .pc_i(pc), .br_off_i(off), .jmp_field_i(jf), .fp_cond_i(fpc),
    .set_o(set_o), .taken_o(taken_o), .next_pc_o(next_pc_o),
    .link_we_o(link_we_o), .link_rd_o(link_rd_o), .link_o(link_o)
  );

  function automatic string tag_of(input logic [4:0] o);
    case (o)
      5'd1, 5'd3, 5'd5, 5'd7:  return "R2";
      5'd2, 5'd4, 5'd6, 5'd8:  return "R3";
      5'd9, 5'd10:             return "R4";
      5'd11, 5'd12:            return "R5";
      5'd13, 5'd14:            return "R6";
      5'd15, 5'd16:            return "R7";
      5'd17, 5'd18:            return "R8";
      5'd19, 5'd21:            return "R10";
      5'd20, 5'd22:            return "R11";
      default:                 return "R12";
    endcase
  endfunction

  // reference model built from the requirements
  function automatic void model(
    input  logic [4:0] o, input logic [63:0] ra, rb, p,
    input  logic [15:0] of, input logic [25:0] jfield, input logic fp,
    output logic [63:0] e_set, output logic e_tk, output logic [63:0] e_npc,
    output logic e_we, output logic [4:0] e_rd, output logic [63:0] e_lnk);
    logic sb, br, jmp;
    logic [63:0] p4, tgt;
    p4 = p + 64'd4;
    sb = 0; br = 0; jmp = 0; tgt = p4;
    case (o)
      5'd1:  sb = $signed(ra) <  $signed(rb);
      5'd2:  sb = ra <  rb;
      5'd3:  sb = $signed(ra) >  $signed(rb);
      5'd4:  sb = ra >  rb;
      5'd5:  sb = $signed(ra) <= $signed(rb);
      5'd6:  sb = ra <= rb;
      5'd7:  sb = $signed(ra) >= $signed(rb);
      5'd8:  sb = ra >= rb;
      5'd9:  sb = ra == rb;
      5'd10: sb = ra != rb;
      5'd11: br = ra == 0;
      5'd12: br = ra != 0;
      5'd13: br = ra[63];
      5'd14: br = !ra[63];
      5'd15: br = ra == rb;
      5'd16: br = ra != rb;
      5'd17: br = fp;
      5'd18: br = !fp;
      5'd19, 5'd20: begin jmp = 1; tgt = {p4[63:28], jfield, 2'b00}; end
      5'd21, 5'd22: begin jmp = 1; tgt = ra; end
      default: ;
    endcase
    if (br) tgt = p4 + {{46{of[15]}}, of, 2'b00};
    e_set = {63'd0, sb};
    e_tk  = br || jmp;
    e_npc = tgt;
    e_we  = (o == 5'd20 || o == 5'd22);
    e_rd  = e_we ? 5'd31 : 5'd0;
    e_lnk = e_we ? p4 : 64'd0;
  endfunction

  task automatic run(input logic [4:0] o, input logic [63:0] ra, rb, p,
                     input logic [15:0] of, input logic [25:0] jfield, input logic fp);
    logic [63:0] e_set, e_npc, e_lnk;
    logic e_tk, e_we;
    logic [4:0] e_rd;
    op = o; a = ra; b = rb; pc = p; off = of; jf = jfield; fpc = fp;
    model(o, ra, rb, p, of, jfield, fp, e_set, e_tk, e_npc, e_we, e_rd, e_lnk);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (set_o !== e_set || taken_o !== e_tk || next_pc_o !== e_npc ||
        link_we_o !== e_we || link_rd_o !== e_rd || link_o !== e_lnk) begin
      fails++;
      $display("FAIL %s (R1/R9 fields) op=%0d: got set=%h tk=%b npc=%h we=%b rd=%0d lnk=%h exp set=%h tk=%b npc=%h we=%b rd=%0d lnk=%h",
               tag_of(o), o, set_o, taken_o, next_pc_o, link_we_o, link_rd_o, link_o,
               e_set, e_tk, e_npc, e_we, e_rd, e_lnk);
    end
  endtask

  function automatic logic [63:0] pick();
    case ($urandom_range(0, 6))
      0: return 64'd0;
      1: return 64'd1;
      2: return '1;
      3: return 64'h8000_0000_0000_0000;
      4: return 64'h7fff_ffff_ffff_ffff;
      default: return {$urandom(), $urandom()};
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hC0DE_1234));
    op = 5'd20; a = '1; b = '1; pc = 64'h100; off = 16'h7; jf = 26'h1; fpc = 1'b1;
    repeat (3) @(negedge clk);
    // R12: reset state
    checks++;
    if (set_o !== 0 || taken_o !== 0 || next_pc_o !== 0 || link_we_o !== 0 ||
        link_rd_o !== 0 || link_o !== 0) begin
      fails++;
      $display("FAIL R12 reset: got tk=%b npc=%h we=%b exp all zero", taken_o, next_pc_o, link_we_o);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners: signed vs unsigned order (R2, R3)
    run(5'd1, 64'h8000_0000_0000_0000, 64'd1, 64'h1000, 16'd0, 26'd0, 0);
    run(5'd2, 64'h8000_0000_0000_0000, 64'd1, 64'h1000, 16'd0, 26'd0, 0);
    run(5'd4, '1, 64'd0, 64'h1000, 16'd0, 26'd0, 0);
    run(5'd3, '1, 64'd0, 64'h1000, 16'd0, 26'd0, 0);
    // equal operands on le/ge/strict (R2, R3, R4)
    run(5'd5, 64'd42, 64'd42, 64'h2000, 16'd0, 26'd0, 0);
    run(5'd8, 64'd42, 64'd42, 64'h2000, 16'd0, 26'd0, 0);
    run(5'd3, 64'd42, 64'd42, 64'h2000, 16'd0, 26'd0, 0);
    run(5'd10, 64'd42, 64'd42, 64'h2000, 16'd0, 26'd0, 0);
    // R5 / R6 / R7 / R8 branches with most negative offset (R9)
    run(5'd11, 64'd0, 64'd5, 64'h0004_0000, 16'h8000, 26'd0, 0);
    run(5'd12, 64'd0, 64'd5, 64'h0004_0000, 16'h8000, 26'd0, 0);
    run(5'd13, 64'h8000_0000_0000_0000, 64'd0, 64'h3000, 16'h7fff, 26'd0, 0);
    run(5'd14, 64'h8000_0000_0000_0000, 64'd0, 64'h3000, 16'h7fff, 26'd0, 0);
    run(5'd15, 64'd9, 64'd9, 64'h3000, 16'hfffe, 26'd0, 0);
    run(5'd17, 64'd0, 64'd0, 64'h3000, 16'h0010, 26'd0, 1);
    run(5'd18, 64'd0, 64'd0, 64'h3000, 16'h0010, 26'd0, 1);
    // R10 / R11: jumps with PC near top of address space
    run(5'd19, 64'd0, 64'd0, 64'hF000_0000_FFFF_FFFC, 16'd0, 26'h3ff_ffff, 0);
    run(5'd20, 64'd0, 64'd0, 64'hA5A5_0000_1234_5678, 16'd0, 26'h155_5555, 0);
    run(5'd22, 64'hDEAD_BEEF_0000_0003, 64'd0, 64'h500, 16'd0, 26'd0, 0);
    run(5'd21, 64'h0000_0000_0000_0040, 64'd0, 64'h500, 16'd0, 26'd0, 0);
    // R12: unused codes behave as NOP
    run(5'd23, '1, '1, 64'h600, 16'h1, 26'h1, 1);
    run(5'd31, '1, 64'd0, 64'h600, 16'h1, 26'h1, 1);
    run(5'd0, 64'd0, 64'd0, 64'h600, 16'h1, 26'h1, 1);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      run(5'($urandom_range(0, 31)), pick(), ($urandom_range(0, 3) == 0) ? 64'd0 : pick(),
          {$urandom(), $urandom()} & ~64'd3, 16'($urandom()), 26'($urandom()), 1'($urandom()));
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule